// File: doc/BRIEF.md
# Converter Microprocessor Bus Interface

This block sits between a host microprocessor bus and an analog-to-digital converter core. The host selects the block with an active-low chip select. An active-low write strobe carries a six-bit command, taken from the low bits of the data bus. An active-low read strobe returns the latest 13-bit result, sign-extended to a 16-bit word. All three strobes come from the host side. They pass through a two-flop synchronizer, and every edge is detected in the converter clock domain.

A write whose command is valid turns into a one-cycle pulse that starts a conversion or a calibration. The pulse appears once the synchronized strobe has been released. A small engine stub stands in for the converter core. It holds a busy flag for the length of the operation, and a new command restarts it. When a conversion finishes, the stub latches the core result and pulls the active-low interrupt. Any strobe falling edge makes the ready output insert a single wait clock. The bidirectional bus is split into an input word, an output word and a drive enable, so that pad logic elsewhere can build the tri-state.

Top module: `cvt_bus_if`

## Requirements
- R1: While reset is held, int_n and ready are 1, and busy, bus_oe, conv_start and cal_start are 0.
- R2: The host holds the command on cmd_in while cs_n and wr_n are both low. The command takes effect when either strobe returns high. After the synchronized release, exactly one one-cycle pulse appears on conv_start or cal_start.
- R3: cmd_in[5:4]=2'b10 together with cmd_in[0]=0 decodes as convert. cmd_in=6'b000000 decodes as calibrate. Any other word produces no start pulse, leaves busy low and leaves int_n unchanged.
- R4: After a start pulse, busy stays high for exactly 24 clocks for a conversion and 300 clocks for a calibration.
- R5: A command accepted while busy is high aborts the running operation and restarts the count. The aborted operation never asserts int_n.
- R6: int_n goes low in the clock where busy drops at the end of a conversion, and the core result is latched at that moment. A finished calibration leaves int_n high.
- R7: While cs_n and rd_n are both low, bus_oe is 1 and bus_out carries the latched result with bit 12 copied into bits 15:13. Otherwise bus_oe is 0 and bus_out is 0.
- R8: A synchronized falling edge of CS·RD clears int_n, and so does a synchronized falling edge of CS·WR.
- R9: A CS·RD falling edge in the same clock as a conversion finishing does not clear int_n. Later read edges do not clear it either. The next CS·WR falling edge clears it.
- R10: ready drops to 0 for exactly one clock after each synchronized falling edge of CS·WR or CS·RD, then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmd_in | input | 6 | Low six bits of the data bus, as seen from the pads |
| bus_out | output | 16 | Data word driven toward the bus during a read |
| bus_oe | output | 1 | Drive enable for the data bus pads |
| result_i | input | 13 | Two's-complement result from the converter core |
| conv_start | output | 1 | One-cycle conversion start pulse |
| cal_start | output | 1 | One-cycle calibration start pulse |
| busy | output | 1 | Engine running |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| ready | output | 1 | Low for one clock to insert a bus wait state |

## Verification
Two events can land in the same clock: a conversion finishing, which sets the interrupt, and a read edge, which would clear it. The bench counts busy clocks after the start pulse. It lowers the read strobe exactly two clocks before the final busy clock, so that the synchronized read edge falls in that final clock. In that case the interrupt must stay low through the read and through a second read, and must clear only on the next write strobe. The same read launched one clock later must clear the interrupt, which shows where the lock boundary lies.

// File: rtl/cvt_bus_if.sv
module cvt_bus_if #(
  parameter int DATA_W      = 16,
  parameter int RES_W       = 13,
  parameter int CMD_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 24,
  parameter int CAL_CYCLES  = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [CMD_W-1:0]  cmd_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [RES_W-1:0]  result_i,
  output logic              conv_start,
  output logic              cal_start,
  output logic              busy,
  output logic              int_n,
  output logic              ready
);

  localparam int MAX_CYC = (CONV_CYCLES > CAL_CYCLES) ? CONV_CYCLES : CAL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC);
  localparam int EXT_W   = DATA_W - RES_W;

  logic [SYNC_STAGES-1:0] cs_sh, wr_sh, rd_sh;
  logic                   wr_act, rd_act, wr_act_d, rd_act_d;
  logic                   wr_fall, wr_rise, rd_fall;
  logic [CMD_W-1:0]       cmd_q;
  logic                   is_conv, is_cal, start_any, done;
  logic [CNT_W-1:0]       cnt;
  logic                   cal_mode, rd_lock;
  logic [RES_W-1:0]       res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '1;
      wr_sh <= '1;
      rd_sh <= '1;
      wr_act_d <= 1'b0;
      rd_act_d <= 1'b0;
    end else begin
      cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      wr_sh <= {wr_sh[SYNC_STAGES-2:0], wr_n};
      rd_sh <= {rd_sh[SYNC_STAGES-2:0], rd_n};
      wr_act_d <= wr_act;
      rd_act_d <= rd_act;
    end
  end

  assign wr_act  = ~cs_sh[SYNC_STAGES-1] & ~wr_sh[SYNC_STAGES-1];
  assign rd_act  = ~cs_sh[SYNC_STAGES-1] & ~rd_sh[SYNC_STAGES-1];
  assign wr_fall = wr_act & ~wr_act_d;
  assign wr_rise = ~wr_act & wr_act_d;
  assign rd_fall = rd_act & ~rd_act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_act) cmd_q <= cmd_in;
  end

  assign is_conv    = (cmd_q[CMD_W-1 -: 2] == 2'b10) && !cmd_q[0];
  assign is_cal     = (cmd_q == '0);
  assign conv_start = wr_rise & is_conv;
  assign cal_start  = wr_rise & is_cal;
  assign start_any  = conv_start | cal_start;
  assign done       = busy && (cnt == '0) && !cal_mode && !start_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cal_mode <= 1'b0;
    end else if (conv_start) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(CONV_CYCLES - 1);
      cal_mode <= 1'b0;
    end else if (cal_start) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(CAL_CYCLES - 1);
      cal_mode <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n   <= 1'b1;
      rd_lock <= 1'b0;
      res_q   <= '0;
    end else if (done) begin
      int_n   <= 1'b0;
      rd_lock <= rd_fall;
      res_q   <= result_i;
    end else if (wr_fall) begin
      int_n   <= 1'b1;
      rd_lock <= 1'b0;
    end else if (rd_fall && !rd_lock) begin
      int_n   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b1;
    else        ready <= ~(wr_fall | rd_fall);
  end

  assign bus_oe  = ~cs_n & ~rd_n;
  assign bus_out = bus_oe ? {{EXT_W{res_q[RES_W-1]}}, res_q} : '0;

endmodule

// File: rtl/cvt_bus_if_chk.sv
module cvt_bus_if_chk #(
  parameter int DATA_W = 16,
  parameter int RES_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe,
  input logic              conv_start,
  input logic              cal_start,
  input logic              busy,
  input logic              int_n,
  input logic              ready
);

  a_r10_ready_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || cal_start) |=> !(conv_start || cal_start));

  a_r3_starts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && cal_start));

  a_r4_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || cal_start) |=> busy);

  a_r6_int_with_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $fell(busy));

  a_r7_sign_copies: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_out[DATA_W-1:RES_W-1] == '0 || bus_out[DATA_W-1:RES_W-1] == '1));

  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

endmodule

bind cvt_bus_if cvt_bus_if_chk #(.DATA_W(DATA_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/test_cvt_bus_if.sv
module test_cvt_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [5:0]  cmd_in = '0;
  logic [12:0] result_i = '0;
  logic [15:0] bus_out;
  logic        bus_oe, conv_start, cal_start, busy, int_n, ready;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  cvt_bus_if i_cvt_bus_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmd_in(cmd_in), .bus_out(bus_out), .bus_oe(bus_oe), .result_i(result_i),
    .conv_start(conv_start), .cal_start(cal_start), .busy(busy),
    .int_n(int_n), .ready(ready)
  );

  // {cmd[5:0], kind[1:0]}: kind 0 = ignored, 1 = convert, 2 = calibrate
  localparam logic [7:0] VEC [8] = '{
    {6'b100000, 2'd1}, {6'b101110, 2'd1}, {6'b100001, 2'd0}, {6'b000000, 2'd2},
    {6'b010000, 2'd0}, {6'b110000, 2'd0}, {6'b101010, 2'd1}, {6'b000001, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ext(input logic [12:0] r);
    return {{3{r[12]}}, r};
  endfunction

  task automatic do_write(input logic [5:0] w, output int nc, output int nk, output int nr);
    nc = 0; nk = 0; nr = 0;
    @(negedge clk); cmd_in = w; cs_n = 1'b0; wr_n = 1'b0;
    for (int j = 0; j < 4; j++) begin @(negedge clk); if (!ready) nr++; end
    cs_n = 1'b1; wr_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (conv_start) nc++;
      if (cal_start) nk++;
      if (conv_start || cal_start) break;
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_read(output logic [15:0] v, output logic oe, output int nr);
    nr = 0;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    #1; v = bus_out; oe = bus_oe;
    for (int j = 0; j < 4; j++) begin @(negedge clk); if (!ready) nr++; end
    cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  // Conversion with a read lowered on busy clock k_rd; returns int_n just after busy drops
  // and int_n after the read has been held three more clocks.
  task automatic conv_with_read(input int k_rd, output logic i_end, output logic i_hold);
    int nc, nk, nr, k;
    do_write(6'b100000, nc, nk, nr);
    k = 0;
    @(negedge clk);
    while (busy && k < 1000) begin
      k++;
      if (k == k_rd) begin cs_n = 1'b0; rd_n = 1'b0; end
      @(negedge clk);
    end
    i_end = int_n;
    repeat (3) @(negedge clk);
    i_hold = int_n;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int nc, nk, nr, nb;
    logic [15:0] v;
    logic oe, i_end, i_hold;
    logic [12:0] r;

    repeat (3) @(negedge clk);
    chk("R1 int_n", int_n, 1);
    chk("R1 ready", ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 starts", conv_start | cal_start, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      r = (i % 2) ? 13'h1ABC - 13'(i) : 13'h0123 + 13'(i);
      result_i = r;
      do_write(VEC[i][7:2], nc, nk, nr);
      chk("R10 write wait", nr, 1);
      chk("R3 convert pulse", nc, (VEC[i][1:0] == 2'd1) ? 1 : 0);
      chk("R3 calibrate pulse", nk, (VEC[i][1:0] == 2'd2) ? 1 : 0);
      if (VEC[i][1:0] != 2'd0) begin
        count_busy(nb);
        chk("R4 busy length", nb, (VEC[i][1:0] == 2'd1) ? 24 : 300);
        chk("R6 interrupt", int_n, (VEC[i][1:0] == 2'd1) ? 0 : 1);
        if (VEC[i][1:0] == 2'd1) begin
          result_i = 13'h0555;
          do_read(v, oe, nr);
          chk("R7 result word", v, ext(r));
          chk("R7 drive enable", oe, 1);
          chk("R10 read wait", nr, 1);
          chk("R8 read clears", int_n, 1);
          chk("R7 released", bus_oe, 0);
        end
      end else begin
        repeat (5) @(negedge clk);
        chk("R3 ignored busy", busy, 0);
        chk("R3 ignored int", int_n, 1);
      end
    end

    // R5: restart a running conversion
    result_i = 13'h1000;
    do_write(6'b100000, nc, nk, nr);
    repeat (3) @(negedge clk);
    do_write(6'b100010, nc, nk, nr);
    chk("R5 second pulse", nc, 1);
    chk("R5 no early int", int_n, 1);
    count_busy(nb);
    chk("R5 restart length", nb, 24);
    do_read(v, oe, nr);
    chk("R5 result", v, 16'hF000);
    chk("R8 cleared", int_n, 1);

    // R5: convert aborts a calibration
    do_write(6'b000000, nc, nk, nr);
    repeat (5) @(negedge clk);
    do_write(6'b100000, nc, nk, nr);
    chk("R5 convert over cal", nc, 1);
    count_busy(nb);
    chk("R5 convert over cal length", nb, 24);
    chk("R6 int after abort", int_n, 0);
    do_write(6'b000001, nc, nk, nr);
    chk("R8 write clears", int_n, 1);

    // R9: read edge in the finishing clock
    conv_with_read(22, i_end, i_hold);
    chk("R9 int set", i_end, 0);
    chk("R9 read ignored", i_hold, 0);
    do_read(v, oe, nr);
    chk("R9 later read ignored", int_n, 0);
    do_write(6'b000001, nc, nk, nr);
    chk("R9 write clears", int_n, 1);

    // R8: read edge one clock after finishing
    conv_with_read(23, i_end, i_hold);
    chk("R8 read after finish clears", i_hold, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule